// File: doc/BRIEF.md
# Byte-Wide SPI Master

This block is a serial peripheral interface master that moves exactly one byte per command. A host on a simple single-cycle register bus loads a transmit byte, sets the clock divisor and the mode, and then writes a start command. The engine shifts the byte out on MOSI while it captures MISO. When the eighth bit has been captured, the engine stores the received byte, sets a ready flag and raises the interrupt line. The host reads the received byte back, and that read clears the flag. No data is queued, so every byte needs its own start command.

Software chooses the serial clock rate, the idle level of SCK, whether data is captured on the leading or the trailing SCK edge, the bit order, and an internal loopback path. Chip selects live outside the block. The host drives them around its byte sequence.

Register bus: a write takes effect on the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational from `bus_addr` while `bus_en` is high and `bus_we` is low. Each access lasts one cycle and there is no wait state or back-pressure: the bus is always ready.

Top module: `spibyte_master`

## Requirements
- R1: After reset, mode (offset 0), divisor (offset 6) and status (offset 4) all read 0, the interrupt is low, SCK is low and MOSI is low.
- R2: The registers sit at fixed byte offsets: 0 mode, 1 received data (read only), 2 transmit data, 3 command (write only, reads 0), 4 status (read only), 6 clock divisor. Offset 5 reads 0. Mode, transmit data and divisor read back the value last written to them. Only mode bits 4..0 are stored; bits 7..5 read 0.
- R3: Mode bit 3 is the enable. When it is 1, a write to offset 3 with bit 0 set starts one transfer. Status bit 1 (busy) then reads 1. The transfer toggles SCK exactly 16 times, and every SCK half-period after the first edge lasts 2·(D+1) clock cycles, where D is the divisor value. The received byte is the byte the slave presented.
- R4: Mode bit 4 selects the capture edge. When it is 1, both sides capture on the leading SCK edge and the first bit is on MOSI before that edge. When it is 0, MOSI changes on the leading edge and both sides capture on the trailing edge.
- R5: Mode bit 1 sets the idle level of SCK: 1 means SCK idles high, 0 means SCK idles low. SCK sits at this level before and after each transfer.
- R6: Mode bit 2 selects the bit order: 1 sends and receives least significant bit first, 0 sends and receives most significant bit first.
- R7: When mode bit 0 (loopback) is set, the capture path takes MOSI instead of the MISO pin. The received byte then equals the transmitted byte, whatever MISO carries.
- R8: When a transfer completes, status bit 0 (ready) and the interrupt rise together while busy still reads 1. Busy reads 0 exactly one clock cycle later.
- R9: A read of offset 1 clears ready and drops the interrupt on the following clock edge.
- R10: While the enable is 0, SCK stays at its idle level, MOSI stays low, and start commands are ignored.
- R11: A start command written while busy is ignored. A transmit-data write made during a transfer does not change the byte being shifted out, and the transfer raises only one completion.
- R12: Clearing the enable during a transfer aborts it. Busy reads 0 on the next cycle, SCK returns to idle, and ready is not raised.
- R13: A write to offset 3 with bit 0 clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and engine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt, high while a received byte awaits reading |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |

## Verification
The bench models a slave that launches and captures on the edge pairs the mode calls for, so a design whose capture edge was swapped would receive a byte shifted by one bit. A design that reversed the wrong side of the bit order would produce a mirrored byte. The bench times every SCK half-period against the divisor, which would expose an off-by-one in the divider or a missing or extra sixteenth edge. It polls busy on each cycle around the completion to confirm the one-cycle gap after ready. It also drives the cases where a careless design would act when it should not: a start while busy (which would restart the shifter or raise a second completion), a start while disabled, a command without the start bit, and an abort partway through a transfer (which would leave busy stuck or raise ready).

// File: rtl/spibyte_pkg.sv
package spibyte_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_RXD  = 3'd1;
  localparam logic [ADDR_W-1:0] OFF_TXD  = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 3'd3;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] OFF_DIV  = 3'd6;

  // field order mirrors mode register bits 4..0
  typedef struct packed {
    logic lead;   // bit 4: capture on leading edge
    logic en;     // bit 3: port enable
    logic lsb;    // bit 2: least significant bit first
    logic cpol;   // bit 1: SCK idles high
    logic loop;   // bit 0: internal loopback
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_RUN  = 2'd1,
    XS_DONE = 2'd2,
    XS_TAIL = 2'd3
  } xfer_state_t;

endpackage

// File: rtl/spibyte_divider.sv
module spibyte_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] cdm,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;

  // half period is 2*(cdm+1) cycles, so terminal count is 2*cdm+1
  assign half_m1 = {cdm, 1'b1};
  assign tick    = run && (cnt_q == half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || tick)    cnt_q <= '0;
    else                      cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/spibyte_shifter.sv
module spibyte_shifter
  import spibyte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              start,
  input  logic              tick,
  input  logic              spi_miso,
  output logic              running,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              spi_sck,
  output logic              spi_mosi
);
  localparam int SR_W      = DATA_W + 1;
  localparam int N_EDGES   = 2 * DATA_W;
  localparam int EDGE_W    = $clog2(N_EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(N_EDGES - 1);

  xfer_state_t        state_q;
  logic [EDGE_W-1:0]  edge_q;
  logic               phase_q;
  logic [SR_W-1:0]    tx_sr_q;
  logic [DATA_W-1:0]  rx_sr_q;
  logic [DATA_W-1:0]  tx_ord;
  logic               miso_in;
  logic               capture;

  // bit order handled by mirroring at load and at unload
  for (genvar i = 0; i < DATA_W; i++) begin : g_order
    assign tx_ord[i]  = mode.lsb ? tx_byte[DATA_W-1-i] : tx_byte[i];
    assign rx_byte[i] = mode.lsb ? rx_sr_q[DATA_W-1-i] : rx_sr_q[i];
  end

  assign running  = (state_q == XS_RUN);
  assign busy     = (state_q != XS_IDLE);
  assign done     = (state_q == XS_DONE);
  assign spi_mosi = running && mode.en && tx_sr_q[SR_W-1];
  assign spi_sck  = mode.cpol ^ (phase_q & mode.en);
  assign miso_in  = mode.loop ? spi_mosi : spi_miso;
  // even edge index = leading edge
  assign capture  = mode.lead ? ~edge_q[0] : edge_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      edge_q  <= '0;
      phase_q <= 1'b0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
    end else if (!mode.en) begin
      state_q <= XS_IDLE;
      phase_q <= 1'b0;
    end else begin
      case (state_q)
        XS_IDLE: begin
          if (start) begin
            state_q <= XS_RUN;
            edge_q  <= '0;
            phase_q <= 1'b0;
            rx_sr_q <= '0;
            // leading-capture presents the first bit now; trailing-capture
            // presents it on the first leading edge
            tx_sr_q <= mode.lead ? {tx_ord, 1'b0} : {1'b0, tx_ord};
          end
        end
        XS_RUN: begin
          if (tick) begin
            phase_q <= ~phase_q;
            edge_q  <= edge_q + EDGE_W'(1);
            if (capture) rx_sr_q <= {rx_sr_q[DATA_W-2:0], miso_in};
            else         tx_sr_q <= {tx_sr_q[SR_W-2:0], 1'b0};
            if (edge_q == LAST_EDGE) state_q <= XS_DONE;
          end
        end
        XS_DONE: state_q <= XS_TAIL;
        XS_TAIL: state_q <= XS_IDLE;
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  p_idle_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XS_IDLE) |-> (!spi_mosi && (spi_sck == mode.cpol)));

  p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.en |=> (state_q == XS_IDLE));

  p_last_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode.en && tick && edge_q == LAST_EDGE) |=> done);

  p_sck_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode.en && !tick) |=> $stable(phase_q));

endmodule

// File: rtl/spibyte_regs.sv
module spibyte_regs
  import spibyte_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_byte,
  output mode_t             mode,
  output logic [DIV_W-1:0]  cdm,
  output logic [DATA_W-1:0] tx_byte,
  output logic              start,
  output logic              irq
);
  mode_t             mode_q;
  logic [DIV_W-1:0]  cdm_q;
  logic [DATA_W-1:0] txd_q;
  logic [DATA_W-1:0] rxd_q;
  logic              rdy_q;
  logic              wr_hit;
  logic              rd_hit;
  logic              rd_rx;

  assign wr_hit = bus_en && bus_we;
  assign rd_hit = bus_en && !bus_we;
  assign rd_rx  = rd_hit && (bus_addr == OFF_RXD);
  assign start  = wr_hit && (bus_addr == OFF_CMD) && bus_wdata[0] && mode_q.en && !busy;

  assign mode    = mode_q;
  assign cdm     = cdm_q;
  assign tx_byte = txd_q;
  assign irq     = rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cdm_q  <= '0;
      txd_q  <= '0;
      rxd_q  <= '0;
      rdy_q  <= 1'b0;
    end else begin
      if (wr_hit) begin
        case (bus_addr)
          OFF_MODE: mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
          OFF_TXD:  txd_q  <= bus_wdata;
          OFF_DIV:  cdm_q  <= bus_wdata[DIV_W-1:0];
          default:  ;
        endcase
      end
      if (done) begin
        rxd_q <= rx_byte;
        rdy_q <= 1'b1;
      end else if (rd_rx) begin
        rdy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      case (bus_addr)
        OFF_MODE: bus_rdata = DATA_W'(mode_q);
        OFF_RXD:  bus_rdata = rxd_q;
        OFF_TXD:  bus_rdata = txd_q;
        OFF_STAT: bus_rdata = DATA_W'({busy, rdy_q});
        OFF_DIV:  bus_rdata = DATA_W'(cdm_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

  p_rd_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !done) |=> !rdy_q);

  p_busy_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> busy ##1 !busy);

endmodule

// File: rtl/spibyte_master.sv
module spibyte_master
  import spibyte_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  mode_t             mode;
  logic [DIV_W-1:0]  cdm;
  logic [DATA_W-1:0] tx_byte;
  logic [DATA_W-1:0] rx_byte;
  logic              start;
  logic              running;
  logic              busy;
  logic              done;
  logic              tick;

  spibyte_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .done      (done),
    .rx_byte   (rx_byte),
    .mode      (mode),
    .cdm       (cdm),
    .tx_byte   (tx_byte),
    .start     (start),
    .irq       (irq)
  );

  spibyte_divider #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (running),
    .cdm   (cdm),
    .tick  (tick)
  );

  spibyte_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .tx_byte  (tx_byte),
    .start    (start),
    .tick     (tick),
    .spi_miso (spi_miso),
    .running  (running),
    .busy     (busy),
    .done     (done),
    .rx_byte  (rx_byte),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi)
  );

endmodule

// File: tb/sim_spibyte_master.sv
`timescale 1ns/1ps
module sim_spibyte_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  logic       spi_sck;
  logic       spi_mosi;
  logic       miso_r = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // slave model state
  logic       s_lead = 1'b1;
  logic       s_lsb = 1'b0;
  logic [7:0] s_byte = '0;
  int         ec = 0;
  int         exp_half = 2;
  int         gap_bad = 0;
  int         last_cyc = 0;
  logic [7:0] capw = '0;
  logic       prev_sck = 1'b0;
  logic       prev_mosi = 1'b0;

  spibyte_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(miso_r)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic wbit(input logic [7:0] b, input int i, input logic l);
    return l ? b[i] : b[7-i];
  endfunction

  always @(negedge clk) begin : slave
    int k;
    int idx;
    if (spi_sck !== prev_sck) begin
      k = ec;
      if ((s_lead ? (k % 2 == 0) : (k % 2 == 1)) && (k / 2 < 8)) capw[k/2] = prev_mosi;
      if (k > 0 && (cyc - last_cyc) != exp_half) gap_bad++;
      last_cyc = cyc;
      ec = k + 1;
      idx = s_lead ? ec / 2 : (ec - 1) / 2;
      if (idx < 8) miso_r = wbit(s_byte, idx, s_lsb);
    end
    prev_sck = spi_sck;
    prev_mosi = spi_mosi;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic setup_mode(input logic [7:0] md, input logic [7:0] cd, input logic [7:0] sb);
    wr(3'd0, md);
    wr(3'd6, cd);
    s_lead = md[4]; s_lsb = md[2]; s_byte = sb;
    exp_half = 2 * (int'(cd) + 1);
    repeat (2) @(negedge clk);
    ec = 0; gap_bad = 0; capw = '0;
    miso_r = wbit(sb, 0, md[2]);
  endtask

  // full transfer with the slave model; tag names the requirement under test
  task automatic do_xfer(input string tag, input logic [7:0] md, input logic [7:0] cd,
                         input logic [7:0] txb, input logic [7:0] sb, input logic [7:0] exp_rx);
    logic [7:0] d;
    logic [7:0] exp_w;
    int waited;
    setup_mode(md, cd, sb);
    wr(3'd2, txb);
    wr(3'd3, 8'h01);
    rd(3'd4, d);
    chk("R3", "busy after start", int'(d[1]), 1);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 3'd4;
    waited = 0;
    while (waited < 20000) begin
      @(negedge clk);
      #1;
      if (irq) break;
      waited++;
    end
    chk("R8", "status at completion", int'(bus_rdata), 8'h03);
    @(negedge clk);
    #1 chk("R8", "status one cycle later", int'(bus_rdata), 8'h01);
    bus_en = 1'b0;
    chk("R3", "SCK edge count", ec, 16);
    chk("R3", "half-period mismatches", gap_bad, 0);
    for (int i = 0; i < 8; i++) exp_w[i] = wbit(txb, i, md[2]);
    chk(tag, "MOSI wire bits", int'(capw), int'(exp_w));
    rd(3'd1, d);
    chk(tag, "received byte", int'(d), int'(exp_rx));
    #1 chk("R9", "irq after data read", int'(irq), 0);
    rd(3'd4, d);
    chk("R9", "status after data read", int'(d), 0);
    chk("R5", "SCK idle after transfer", int'(spi_sck), int'(md[1]));
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(3'd0, d); chk("R1", "mode", int'(d), 0);
    rd(3'd6, d); chk("R1", "divisor", int'(d), 0);
    rd(3'd4, d); chk("R1", "status", int'(d), 0);
    chk("R1", "irq", int'(irq), 0);
    chk("R1", "sck", int'(spi_sck), 0);
    chk("R1", "mosi", int'(spi_mosi), 0);
  endtask

  task automatic t_regmap;
    logic [7:0] d;
    wr(3'd6, 8'h5A); rd(3'd6, d); chk("R2", "divisor readback", int'(d), 8'h5A);
    wr(3'd2, 8'hC3); rd(3'd2, d); chk("R2", "tx readback", int'(d), 8'hC3);
    wr(3'd0, 8'hF6); rd(3'd0, d); chk("R2", "mode readback", int'(d), 8'h16);
    rd(3'd5, d); chk("R2", "unused offset", int'(d), 0);
    rd(3'd3, d); chk("R2", "command reads zero", int'(d), 0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    setup_mode(8'h02, 8'h00, 8'h00);
    #1 chk("R10", "sck idles high while disabled", int'(spi_sck), 1);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'h01);
    rd(3'd4, d); chk("R10", "no busy while disabled", int'(d), 0);
    repeat (60) @(negedge clk);
    chk("R10", "no SCK edges while disabled", ec, 0);
    chk("R10", "mosi low while disabled", int'(spi_mosi), 0);
    chk("R10", "irq while disabled", int'(irq), 0);
  endtask

  task automatic t_no_start_bit;
    logic [7:0] d;
    setup_mode(8'h18, 8'h00, 8'h00);
    wr(3'd3, 8'hFE);
    rd(3'd4, d); chk("R13", "busy after command without start bit", int'(d), 0);
    repeat (60) @(negedge clk);
    chk("R13", "no SCK edges", ec, 0);
  endtask

  task automatic t_start_while_busy;
    logic [7:0] d;
    logic [7:0] exp_w;
    setup_mode(8'h18, 8'h03, 8'h4B);
    wr(3'd2, 8'h11);
    wr(3'd3, 8'h01);
    repeat (10) @(negedge clk);
    wr(3'd2, 8'hEE);
    wr(3'd3, 8'h01);
    repeat (200) @(negedge clk);
    chk("R11", "irq after first byte", int'(irq), 1);
    for (int i = 0; i < 8; i++) exp_w[i] = wbit(8'h11, i, 1'b0);
    chk("R11", "shifted byte unchanged", int'(capw), int'(exp_w));
    chk("R11", "edge count", ec, 16);
    rd(3'd1, d); chk("R11", "received byte", int'(d), 8'h4B);
    repeat (200) @(negedge clk);
    chk("R11", "no second completion", int'(irq), 0);
    rd(3'd4, d); chk("R11", "idle status", int'(d), 0);
  endtask

  task automatic t_abort;
    logic [7:0] d;
    setup_mode(8'h1A, 8'h04, 8'h00);
    wr(3'd2, 8'hA5);
    wr(3'd3, 8'h01);
    repeat (30) @(negedge clk);
    wr(3'd0, 8'h12);
    rd(3'd4, d); chk("R12", "busy after abort", int'(d), 0);
    #1 chk("R12", "sck back to idle", int'(spi_sck), 1);
    repeat (200) @(negedge clk);
    chk("R12", "no ready after abort", int'(irq), 0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    do_xfer("R3", 8'h18, 8'h00, 8'hA5, 8'h3C, 8'h3C);
    do_xfer("R4", 8'h08, 8'h02, 8'h96, 8'h71, 8'h71);
    do_xfer("R5", 8'h1A, 8'h01, 8'h2D, 8'hB8, 8'hB8);
    do_xfer("R5", 8'h0A, 8'h00, 8'hE1, 8'h07, 8'h07);
    do_xfer("R6", 8'h0E, 8'h01, 8'h01, 8'h80, 8'h80);
    do_xfer("R6", 8'h1C, 8'h00, 8'hC4, 8'h35, 8'h35);
    do_xfer("R7", 8'h19, 8'h00, 8'h5C, 8'hFF, 8'h5C);
    do_xfer("R7", 8'h0D, 8'h02, 8'h93, 8'h00, 8'h93);
    t_disabled();
    t_no_start_bit();
    t_start_while_busy();
    t_abort();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule